// File: doc/BRIEF.md
# SPI Memory Operation Sequencer

This block runs one complete serial-flash operation after a single start command. It first sends an opcode phase, then one phase that holds the address and dummy bytes together, then an optional data phase. The opcode always goes out on one lane. The later phases use one, two or four lanes in half-duplex fashion. The data phase is split into packets, and its length is the packet length times the packet count. With pausing disabled, the packets run back to back. With pausing enabled, the sequencer stops after every packet except the last and waits for a resume command.

Bytes to transmit come from a ready/valid byte stream in a fixed order: opcode bytes, address bytes, dummy bytes (the supplier provides these as 0xFF), and then any write data. Received bytes leave on a valid-only byte stream. A separate timing block supplies `shift_en`, a strobe that allows one lane-group step. The sequencer drives the lane outputs and their output enables, and raises a sticky done flag when the operation completes.

Top module: `spi_mem_seq`

## Requirements
- R1: After reset, `busy`, `done`, `paused`, `tx_ready`, `rx_valid` and `sio_oe` are all 0.
- R2: A `start` seen while idle captures every configuration input. It then pulls `cmd_len` opcode bytes, then `ad_len` address/dummy bytes, then any write data from the transmit stream in that order, and shifts each byte out completely before it pulls the next one.
- R3: Opcode bytes always use a single lane: the bit is on `sio_out[0]`, `sio_oe` is 4'b0001, and there are eight steps per byte. A `cmd_len` of 0 skips the opcode phase.
- R4: `pin_mode` sets the lane count for the data phase: 0 gives 1 lane, 1 gives 2 lanes, 2 gives 4 lanes, and 3 behaves as 1 lane. Each step sends the next most significant bits of the byte, and the highest active lane carries the most significant bit. `sio_oe` is 4'b0001, 4'b0011 or 4'b1111 to match.
- R5: When `xmode` is 1, the address/dummy phase uses one lane and the data phase still uses the `pin_mode` lane count. When `xmode` is 0, both phases use the `pin_mode` lane count.
- R6: When `rx_dir` is 1, the data phase receives and `sio_oe` is 0 throughout it. Each step samples `sio_in`, with the most significant bit on the highest lane. Single-lane receive samples `sio_in[1]`. The received byte appears on `rx_data` with a one-cycle `rx_valid`, one cycle after the step that completes it.
- R7: When `no_data` is 1, the operation completes after the address/dummy phase. It pulls no data bytes and delivers none.
- R8: The data phase moves exactly (`pkt_len_m1`+1) × (`pkt_loop_m1`+1) bytes.
- R9: With `pause_en` 0, packets follow each other with no pause. With `pause_en` 1, `paused` rises after each packet except the last. While paused, no step occurs and `sio_oe` is 0. `resume` continues the operation from the next packet. `resume` has no effect when the sequencer is not paused.
- R10: `tx_lsb`=1 sends each transmit byte least significant bit first. `rx_lsb`=1 takes the first received bit as bit 0 of `rx_data`. When either bit is 0, that direction is most significant bit first.
- R11: `done` rises in the cycle after the last step, or in the cycle after `start` if the operation has no phases. `busy` is 0 whenever `done` is 1. `done` clears at the next accepted `start`. A `start` while busy is ignored.
- R12: A step happens only in a cycle with `shift_en` 1. A transmit phase waits without stepping while the transmit stream has no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation from idle |
| resume | input | 1 | Continue a paused operation |
| cmd_len | input | BLEN_W | Opcode byte count |
| ad_len | input | BLEN_W | Address plus dummy byte count |
| no_data | input | 1 | Skip the data phase |
| pin_mode | input | 2 | Lane count code |
| xmode | input | 1 | Address/dummy phase on one lane |
| rx_dir | input | 1 | Data phase receives |
| pause_en | input | 1 | Pause between packets |
| tx_lsb | input | 1 | Transmit bit order, LSB first |
| rx_lsb | input | 1 | Receive bit order, LSB first |
| pkt_len_m1 | input | LEN_W | Bytes per packet minus one |
| pkt_loop_m1 | input | LOOP_W | Packet count minus one |
| shift_en | input | 1 | Step strobe from timing block |
| tx_valid | input | 1 | Transmit byte available |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmit byte taken this cycle if valid |
| rx_valid | output | 1 | Received byte strobe |
| rx_data | output | 8 | Received byte |
| sio_in | input | 4 | Lane inputs |
| sio_out | output | 4 | Lane outputs |
| sio_oe | output | 4 | Lane output enables |
| busy | output | 1 | Operation in progress |
| paused | output | 1 | Waiting for resume |
| done | output | 1 | Sticky completion flag |

## Verification
The tests cover single-lane writes across two packets, quad reads, dual reads and wide writes with `xmode` set, operations with no data, least-significant-bit-first transfers in both directions, and pausing over three packets. Each test checks every lane group against its expected value. This separates a wrong lane count, a wrong lane mapping or bit order, and a wrong phase boundary. Sparse `shift_en` and a gappy transmit stream show that steps depend only on the strobe and on the arrival of each byte. A spurious start in mid-operation, and a resume while idle, would each show up as extra or missing lane groups.

// File: rtl/spi_mem_seq.sv
module spi_mem_seq #(
  parameter int LEN_W  = 16,
  parameter int LOOP_W = 8,
  parameter int BLEN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              resume,
  input  logic [BLEN_W-1:0] cmd_len,
  input  logic [BLEN_W-1:0] ad_len,
  input  logic              no_data,
  input  logic [1:0]        pin_mode,
  input  logic              xmode,
  input  logic              rx_dir,
  input  logic              pause_en,
  input  logic              tx_lsb,
  input  logic              rx_lsb,
  input  logic [LEN_W-1:0]  pkt_len_m1,
  input  logic [LOOP_W-1:0] pkt_loop_m1,
  input  logic              shift_en,
  input  logic              tx_valid,
  input  logic [7:0]        tx_data,
  output logic              tx_ready,
  output logic              rx_valid,
  output logic [7:0]        rx_data,
  input  logic [3:0]        sio_in,
  output logic [3:0]        sio_out,
  output logic [3:0]        sio_oe,
  output logic              busy,
  output logic              paused,
  output logic              done
);

  localparam logic [1:0] LANE1 = 2'd0;
  localparam logic [1:0] LANE2 = 2'd1;
  localparam logic [1:0] LANE4 = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_AD, S_DATA, S_PAUSE} st_t;

  st_t               st, nxt, after_cmd, after_ad, first_st;
  logic [BLEN_W-1:0] c_cmd_len, c_ad_len;
  logic              c_nodata, c_xmode, c_rx, c_pause, c_txlsb, c_rxlsb;
  logic [1:0]        c_pm;
  logic [LEN_W-1:0]  c_plen, bcnt;
  logic [LOOP_W-1:0] c_ploop, pcnt;
  logic [7:0]        sh, sh_next, rsh, rsh_next;
  logic [2:0]        scnt, last_step;
  logic [1:0]        mode;
  logic              loaded, done_r, rx_valid_r;
  logic [7:0]        rx_data_r;
  logic              tx_phase, rx_phase, step, byte_end, phase_last, pkt_last;

  function automatic logic [7:0] rev8(input logic [7:0] b);
    for (int i = 0; i < 8; i++) rev8[i] = b[7-i];
  endfunction

  assign tx_phase = (st == S_CMD) || (st == S_AD) || (st == S_DATA && !c_rx);
  assign rx_phase = (st == S_DATA) && c_rx;
  assign tx_ready = tx_phase && !loaded;
  assign step     = shift_en && (rx_phase || (tx_phase && loaded));
  assign byte_end = step && (scnt == last_step);
  assign pkt_last = (pcnt == c_ploop);
  assign busy     = (st != S_IDLE);
  assign paused   = (st == S_PAUSE);
  assign done     = done_r;
  assign rx_valid = rx_valid_r;
  assign rx_data  = rx_data_r;

  always_comb begin
    logic [1:0] pm_eff;
    pm_eff = (c_pm == 2'd3) ? LANE1 : c_pm;
    case (st)
      S_CMD:   mode = LANE1;
      S_AD:    mode = c_xmode ? LANE1 : pm_eff;
      default: mode = pm_eff;
    endcase
  end

  always_comb begin
    case (mode)
      LANE1: begin
        last_step = 3'd7;
        sh_next   = {sh[6:0], 1'b0};
        rsh_next  = {rsh[6:0], sio_in[1]};
        sio_out   = {3'b000, sh[7]};
        sio_oe    = tx_phase ? 4'b0001 : 4'b0000;
      end
      LANE2: begin
        last_step = 3'd3;
        sh_next   = {sh[5:0], 2'b00};
        rsh_next  = {rsh[5:0], sio_in[1:0]};
        sio_out   = {2'b00, sh[7:6]};
        sio_oe    = tx_phase ? 4'b0011 : 4'b0000;
      end
      default: begin
        last_step = 3'd1;
        sh_next   = {sh[3:0], 4'b0000};
        rsh_next  = {rsh[3:0], sio_in};
        sio_out   = sh[7:4];
        sio_oe    = tx_phase ? 4'b1111 : 4'b0000;
      end
    endcase
    if (!tx_phase) sio_out = 4'b0000;
  end

  always_comb begin
    after_cmd = (c_ad_len != '0) ? S_AD : (c_nodata ? S_IDLE : S_DATA);
    after_ad  = c_nodata ? S_IDLE : S_DATA;
    first_st  = (cmd_len != '0) ? S_CMD :
                (ad_len != '0)  ? S_AD  :
                no_data         ? S_IDLE : S_DATA;
    case (st)
      S_CMD:   phase_last = (bcnt == LEN_W'(c_cmd_len) - LEN_W'(1));
      S_AD:    phase_last = (bcnt == LEN_W'(c_ad_len) - LEN_W'(1));
      default: phase_last = (bcnt == c_plen);
    endcase
    case (st)
      S_CMD:   nxt = after_cmd;
      S_AD:    nxt = after_ad;
      S_DATA:  nxt = pkt_last ? S_IDLE : (c_pause ? S_PAUSE : S_DATA);
      default: nxt = st;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      c_cmd_len  <= '0;
      c_ad_len   <= '0;
      c_nodata   <= 1'b0;
      c_xmode    <= 1'b0;
      c_rx       <= 1'b0;
      c_pause    <= 1'b0;
      c_txlsb    <= 1'b0;
      c_rxlsb    <= 1'b0;
      c_pm       <= LANE1;
      c_plen     <= '0;
      c_ploop    <= '0;
      bcnt       <= '0;
      pcnt       <= '0;
      sh         <= '0;
      rsh        <= '0;
      scnt       <= '0;
      loaded     <= 1'b0;
      done_r     <= 1'b0;
      rx_valid_r <= 1'b0;
      rx_data_r  <= '0;
    end else begin
      rx_valid_r <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          c_cmd_len <= cmd_len;
          c_ad_len  <= ad_len;
          c_nodata  <= no_data;
          c_xmode   <= xmode;
          c_rx      <= rx_dir;
          c_pause   <= pause_en;
          c_txlsb   <= tx_lsb;
          c_rxlsb   <= rx_lsb;
          c_pm      <= pin_mode;
          c_plen    <= pkt_len_m1;
          c_ploop   <= pkt_loop_m1;
          bcnt      <= '0;
          pcnt      <= '0;
          scnt      <= '0;
          loaded    <= 1'b0;
          st        <= first_st;
          done_r    <= (first_st == S_IDLE);
        end
        S_PAUSE: if (resume) st <= S_DATA;
        default: begin
          if (tx_ready && tx_valid) begin
            sh     <= c_txlsb ? rev8(tx_data) : tx_data;
            loaded <= 1'b1;
          end
          if (step) begin
            scnt <= scnt + 3'd1;
            sh   <= sh_next;
            rsh  <= rsh_next;
            if (byte_end) begin
              scnt   <= '0;
              loaded <= 1'b0;
              if (rx_phase) begin
                rx_valid_r <= 1'b1;
                rx_data_r  <= c_rxlsb ? rev8(rsh_next) : rsh_next;
              end
              if (!phase_last) begin
                bcnt <= bcnt + 1'b1;
              end else begin
                bcnt <= '0;
                st   <= nxt;
                if (nxt == S_IDLE) done_r <= 1'b1;
                if (st == S_DATA && !pkt_last) pcnt <= pcnt + 1'b1;
              end
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/spi_mem_seq_chk.sv
module spi_mem_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       resume,
  input logic       shift_en,
  input logic       tx_ready,
  input logic       rx_valid,
  input logic [3:0] sio_oe,
  input logic       busy,
  input logic       paused,
  input logic       done
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sio_oe == 4'b0000 && !tx_ready));  // R1

  AST_OE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (sio_oe == 4'b0000 || sio_oe == 4'b0001 || sio_oe == 4'b0011 || sio_oe == 4'b1111));  // R4

  AST_RX_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(sio_oe) == 4'b0000);  // R6

  AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> (sio_oe == 4'b0000 && !tx_ready));  // R9

  AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    paused && !resume |=> paused);  // R9

  AST_RESUME_GO: assert property (@(posedge clk) disable iff (!rst_n)
    paused && resume |=> busy && !paused);  // R9

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);  // R11

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> busy || done);  // R11

  AST_RX_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(shift_en));  // R12

endmodule

bind spi_mem_seq spi_mem_seq_chk i_chk (.*);

// File: tb/test_spi_mem_seq.sv
module test_spi_mem_seq;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, resume = 1'b0;
  logic [3:0]  cmd_len = '0, ad_len = '0;
  logic        no_data = 1'b0, xmode = 1'b0, rx_dir = 1'b0, pause_en = 1'b0;
  logic        tx_lsb = 1'b0, rx_lsb = 1'b0;
  logic [1:0]  pin_mode = '0;
  logic [15:0] pkt_len_m1 = '0;
  logic [7:0]  pkt_loop_m1 = '0;
  logic        shift_en = 1'b1, tx_valid = 1'b0;
  logic [7:0]  tx_data = '0;
  logic        tx_ready, rx_valid;
  logic [7:0]  rx_data;
  logic [3:0]  sio_in = '0, sio_out, sio_oe;
  logic        busy, paused, done;

  logic [7:0] tx_q[$];
  logic [7:0] exp_grp[$];
  logic [3:0] dev_q[$];
  logic [7:0] exp_rx[$];
  int    n_tests = 0, n_fail = 0, cyc = 0;
  bit    slow = 1'b0, gappy = 1'b0, took_tx = 1'b0, took_rx = 1'b0;
  string cur_req = "R1";

  spi_mem_seq i_spi_mem_seq (.*);

  always #(HALF) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] b);
    for (int i = 0; i < 8; i++) rev8[i] = b[7-i];
  endfunction

  task automatic push_tx_byte(input logic [7:0] b, input int mode, input bit lsb);
    logic [7:0] w;
    tx_q.push_back(b);
    w = lsb ? rev8(b) : b;
    if (mode == 0) for (int i = 7; i >= 0; i--) exp_grp.push_back({4'b0001, 3'b000, w[i]});
    else if (mode == 1) for (int i = 3; i >= 0; i--) exp_grp.push_back({4'b0011, 2'b00, w[2*i+1], w[2*i]});
    else begin exp_grp.push_back({4'b1111, w[7:4]}); exp_grp.push_back({4'b1111, w[3:0]}); end
  endtask

  task automatic push_rx_byte(input logic [7:0] b, input int mode, input bit lsb);
    logic [7:0] w;
    exp_rx.push_back(b);
    w = lsb ? rev8(b) : b;
    if (mode == 0) for (int i = 7; i >= 0; i--) dev_q.push_back({2'b00, w[i], 1'b0});
    else if (mode == 1) for (int i = 3; i >= 0; i--) dev_q.push_back({2'b00, w[2*i+1], w[2*i]});
    else begin dev_q.push_back(w[7:4]); dev_q.push_back(w[3:0]); end
  endtask

  // per-cycle driver and monitor: drive at negedge, sample just before posedge
  always begin
    @(negedge clk);
    if (rx_valid) begin
      if (exp_rx.size() == 0) chk(1'b0, cur_req, {24'h0, rx_data}, 32'hDEAD);
      else begin
        logic [7:0] e;
        e = exp_rx.pop_front();
        chk(rx_data == e, cur_req, {24'h0, rx_data}, {24'h0, e});
      end
    end
    if (took_tx && tx_q.size() > 0) void'(tx_q.pop_front());
    if (took_rx && dev_q.size() > 0) void'(dev_q.pop_front());
    shift_en = slow ? (cyc % 3 == 0) : 1'b1;
    tx_valid = (tx_q.size() > 0) && (!gappy || (cyc % 4 < 2));
    tx_data  = (tx_q.size() > 0) ? tx_q[0] : 8'h00;
    sio_in   = (dev_q.size() > 0) ? dev_q[0] : 4'h0;
    #(HALF - 1);
    took_tx = tx_valid && tx_ready;
    took_rx = shift_en && busy && !paused && (sio_oe == 4'b0000);
    if (shift_en && sio_oe != 4'b0000 && !tx_ready) begin
      if (exp_grp.size() == 0) chk(1'b0, cur_req, {24'h0, sio_oe, sio_out}, 32'hDEAD);
      else begin
        logic [7:0] e;
        e = exp_grp.pop_front();
        chk({sio_oe, sio_out} == e, cur_req, {24'h0, sio_oe, sio_out}, {24'h0, e});
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog R11: actual no completion expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic run_op(input string req, input int ncmd, input logic [7:0] opc,
                        input int naddr, input logic [31:0] addr, input int ndum,
                        input bit nod, input int pm, input bit xm, input bit rxd,
                        input bit pse, input bit txl, input bit rxl,
                        input int plen, input int ploop, input logic [7:0] seed,
                        input bit poke);
    int pme, adm, npause, k, sz;
    bit imm;
    pme = (pm == 3) ? 0 : pm;
    adm = xm ? 0 : pme;
    npause = 0; k = 0;
    cur_req = req;
    for (int i = 0; i < ncmd; i++) push_tx_byte(8'(opc + i), 0, txl);
    for (int i = 0; i < naddr; i++) push_tx_byte(8'(addr >> (8 * (naddr - 1 - i))), adm, txl);
    for (int i = 0; i < ndum; i++) push_tx_byte(8'hFF, adm, txl);
    if (!nod)
      for (int i = 0; i < (plen + 1) * (ploop + 1); i++)
        if (rxd) push_rx_byte(8'(seed + i * 37), pme, rxl);
        else     push_tx_byte(8'(seed + i * 37), pme, txl);
    cmd_len = 4'(ncmd); ad_len = 4'(naddr + ndum); no_data = nod;
    pin_mode = 2'(pm); xmode = xm; rx_dir = rxd; pause_en = pse;
    tx_lsb = txl; rx_lsb = rxl; pkt_len_m1 = 16'(plen); pkt_loop_m1 = 8'(ploop);
    imm = (ncmd == 0) && (naddr + ndum == 0) && nod;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (imm) chk(done && !busy, "R11", {busy, done}, 2'b01);
    else     chk(busy && !done, "R11", {busy, done}, 2'b10);
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (!done && k < 20000) begin
      if (paused) begin
        npause++;
        @(negedge clk); #1;
        sz = exp_grp.size() + dev_q.size();
        repeat (4) @(negedge clk);
        #1;
        chk(paused && (exp_grp.size() + dev_q.size()) == sz, "R9", exp_grp.size() + dev_q.size(), sz);
        @(negedge clk); resume = 1'b1;
        @(negedge clk); resume = 1'b0;
      end else begin
        @(negedge clk); k++;
      end
    end
    chk(done && !busy, req, {busy, done}, 2'b01);
    chk(npause == (pse ? ploop : 0), "R9", npause, pse ? ploop : 0);
    repeat (2) @(negedge clk);
    #1;
    chk(tx_q.size() == 0 && exp_grp.size() == 0, req, tx_q.size() + exp_grp.size(), 0);
    chk(dev_q.size() == 0 && exp_rx.size() == 0, req, dev_q.size() + exp_rx.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, paused, tx_ready, rx_valid} == 5'b0 && sio_oe == 4'b0, "R1",
        {busy, done, paused, tx_ready, rx_valid, sio_oe}, 0);

    // single-lane write over two packets
    run_op("R2 R3 R8", 1, 8'h02, 3, 32'h012345, 1, 0, 0, 0, 0, 0, 0, 0, 1, 1, 8'h10, 0);
    // quad read, address on four lanes
    run_op("R4 R6", 1, 8'hEB, 3, 32'hABCDEF, 1, 0, 2, 0, 1, 0, 0, 0, 3, 0, 8'h5A, 0);
    // quad write with single-lane address
    run_op("R5", 1, 8'h32, 3, 32'h00F0A5, 0, 0, 2, 1, 0, 0, 0, 0, 5, 0, 8'hC3, 0);
    // dual read with single-lane address and dummy
    run_op("R4 R5 R6", 1, 8'h3B, 3, 32'h123456, 1, 0, 1, 1, 1, 0, 0, 0, 2, 1, 8'h21, 0);
    // no data phase
    run_op("R7", 1, 8'h06, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 3, 0, 8'h00, 0);
    run_op("R7", 1, 8'hB7, 2, 32'h0000BEEF, 0, 1, 1, 0, 1, 0, 0, 0, 3, 0, 8'h00, 0);
    // bit order
    run_op("R10", 1, 8'h03, 2, 32'h00001234, 0, 0, 0, 0, 1, 0, 1, 1, 3, 0, 8'h81, 0);
    run_op("R10", 1, 8'h12, 1, 32'h000000C1, 0, 0, 1, 0, 0, 0, 1, 0, 2, 0, 8'h37, 0);
    // pausing between three packets
    run_op("R9", 1, 8'h0B, 3, 32'h00A0B0, 1, 0, 1, 0, 1, 1, 0, 0, 2, 2, 8'h44, 0);
    // resume while idle is ignored
    @(negedge clk); resume = 1'b1;
    @(negedge clk); resume = 1'b0;
    chk(!busy && !paused, "R9", {busy, paused}, 0);
    // spurious start mid-operation
    run_op("R11", 1, 8'h02, 2, 32'h00000ACE, 0, 0, 0, 0, 0, 0, 0, 0, 3, 0, 8'h66, 1);
    // operation with no phases completes at once
    run_op("R11", 0, 8'h00, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 8'h00, 0);
    // sparse strobe, gappy stream, two opcode bytes, code 3 as one lane
    slow = 1'b1; gappy = 1'b1;
    run_op("R3 R4 R12", 2, 8'h9E, 1, 32'h0000007F, 1, 0, 3, 0, 0, 0, 0, 0, 2, 1, 8'h90, 0);
    run_op("R12", 1, 8'h6B, 1, 32'h00000011, 0, 0, 2, 0, 1, 0, 0, 0, 3, 0, 8'h0F, 0);
    slow = 1'b0; gappy = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule